// File: doc/BRIEF.md
# 64-bit Alarm Timer with Coherent Snapshot

This block is a 64-bit time base that sits behind a 32-bit register port. The count moves by one on every clock while it runs, upward or downward as software chooses. Software can also force a new count at any time from a 64-bit reload value. A 32-bit bus cannot read a 64-bit value in one access, so the count is read through a snapshot. A write to a trigger address freezes the whole count in a holding register, and software then reads its two halves at leisure.

A 64-bit alarm value is compared with the count. When alarm checking is armed, the alarm fires once the count has reached the alarm value or gone past it. Going past means above the alarm value when counting up, and below it when counting down. An alarm value written after the count has already passed it therefore fires at once. Each alarm disarms itself. It sets a sticky status bit that drives the interrupt output through a mask. If auto-reload is selected, the alarm also puts the reload value back into the count.

Top module: `alarm_timer64`

## Requirements
- R1: After reset every register reads zero, except the configuration word, which reads 0x4000_0000 (stopped, counting up). The interrupt output is low.
- R2: While the run bit (config bit 31) is 1, the count changes by exactly one per clock. It goes up when the direction bit (config bit 30) is 1 and down when it is 0, and it wraps modulo 2^64. While the run bit is 0 the count holds.
- R3: A write of any data to offset 0x0C copies the full 64-bit count, as it stood before that clock edge, into the snapshot. Offset 0x04 reads the snapshot's low word and offset 0x08 its high word. Both words keep their value until the next write to 0x0C, however the count moves in between.
- R4: A write of any data to offset 0x20 replaces the count with the reload value (high word at 0x1C, low word at 0x18). This takes priority over counting and over an alarm reload in the same cycle.
- R5: With alarm checking armed (config bit 10), the alarm fires in any cycle where count >= alarm value while counting up, or count <= alarm value while counting down (high word at 0x14, low word at 0x10). An equal count fires, and so does a count already past the alarm value when checking is armed.
- R6: An alarm clears config bit 10, so each arming gives exactly one alarm. A configuration write in the same cycle takes precedence.
- R7: When config bit 29 is 1, an alarm loads the reload value into the count on the next edge instead of incrementing or decrementing it.
- R8: Each alarm sets a status bit that reads as bit 0 at offset 0x24. Writing 1 to bit 0 of 0x24 clears it, writing 0 leaves it set, and a new alarm wins over a clear in the same cycle. The interrupt output equals the status bit ANDed with the mask bit (bit 0 at 0x28) and changes on the same edge as the status.
- R9: Read data is registered and appears one clock after the address. Offsets 0x10, 0x14, 0x18, 0x1C and bit 0 of 0x28 read back what was written. Unused config bits and unmapped offsets read zero. Writes to 0x04 and 0x08 have no effect.
- R10: A change of the direction bit while running takes effect from the next counting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset of the register accessed |
| bus_we | input | 1 | Write strobe for this cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Masked alarm interrupt, registered |

## Verification
The count is tried from several starting points.

- A snapshot taken while the low word rolls over shows whether the two halves are captured together. A second read much later shows whether the snapshot really holds.
- Alarm values set below the count while counting up, and above it while counting down, separate "reached or passed" from plain equality. An alarm placed ahead of an up-counting count shows that equality alone also fires.
- A down-counting run with auto-reload tells a reload apart from a plain decrement through the count that follows.
- Clear writes with bit 0 at 0 and at 1 separate the sticky status from a pulse.

A behavioural model compares read data and the interrupt on every clock, which also catches timing slips in the order of priorities.

// File: rtl/at_pkg.sv
package at_pkg;

  // Byte offsets of the register port
  localparam int OFS_CFG      = 'h00;
  localparam int OFS_SNAP_LO  = 'h04;
  localparam int OFS_SNAP_HI  = 'h08;
  localparam int OFS_SNAP_TRG = 'h0C;
  localparam int OFS_ALM_LO   = 'h10;
  localparam int OFS_ALM_HI   = 'h14;
  localparam int OFS_RLD_LO   = 'h18;
  localparam int OFS_RLD_HI   = 'h1C;
  localparam int OFS_LOAD_TRG = 'h20;
  localparam int OFS_STAT_CLR = 'h24;
  localparam int OFS_IRQ_MASK = 'h28;

  // Configuration word bit positions
  localparam int CFG_RUN_BIT  = 31;
  localparam int CFG_UP_BIT   = 30;
  localparam int CFG_ARL_BIT  = 29;
  localparam int CFG_ARM_BIT  = 10;

  typedef struct packed {
    logic run;       // count enable
    logic up;        // 1: increment, 0: decrement
    logic auto_rl;   // reload on alarm
    logic armed;     // alarm checking armed
  } tcfg_t;

  localparam tcfg_t CFG_RESET = '{run: 1'b0, up: 1'b1, auto_rl: 1'b0, armed: 1'b0};

endpackage

// File: rtl/at_alarm.sv
// Reached-or-passed comparator; direction selects which side counts as passed.
module at_alarm #(
  parameter int W = 64
) (
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] alarm,
  input  logic         up,
  input  logic         armed,
  output logic         fire
);
  logic at_or_above;
  logic at_or_below;

  always_comb begin
    at_or_above = (cnt >= alarm);
    at_or_below = (cnt <= alarm);
    fire        = armed & (up ? at_or_above : at_or_below);
  end
endmodule

// File: rtl/at_counter.sv
// Time-base register with load / reload priority, plus the read snapshot.
module at_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         up,
  input  logic         sw_load,
  input  logic         alarm_reload,
  input  logic [W-1:0] reload_val,
  input  logic         snap_req,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] snap_q
);
  logic [W-1:0] step_val;

  always_comb begin
    step_val = up ? cnt_q + W'(1) : cnt_q - W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (sw_load) begin
      cnt_q <= reload_val;
    end else if (alarm_reload) begin
      cnt_q <= reload_val;
    end else if (run) begin
      cnt_q <= step_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
    end else if (snap_req) begin
      snap_q <= cnt_q;
    end
  end
endmodule

// File: rtl/at_regs.sv
// Register bank: decode, configuration, alarm/reload words, status, mask, read mux.
module at_regs
  import at_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [AW-1:0]   addr,
  input  logic            we,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] snap,
  input  logic            fire,
  output tcfg_t           cfg,
  output logic [2*DW-1:0] alarm_val,
  output logic [2*DW-1:0] reload_val,
  output logic            load_req,
  output logic            snap_req,
  output logic [DW-1:0]   rdata,
  output logic            irq
);
  localparam int NW = 2;
  localparam int BYTES_PER_WORD = DW / 8;

  logic  cfg_wr, clr_wr, mask_wr;
  logic  stat_q, stat_d, mask_q, mask_d;
  tcfg_t cfg_q;
  logic [DW-1:0] rd_d, cfg_word;

  always_comb begin
    cfg_wr   = we && (addr == AW'(OFS_CFG));
    clr_wr   = we && (addr == AW'(OFS_STAT_CLR));
    mask_wr  = we && (addr == AW'(OFS_IRQ_MASK));
    load_req = we && (addr == AW'(OFS_LOAD_TRG));
    snap_req = we && (addr == AW'(OFS_SNAP_TRG));
  end

  // Two-word registers, one write decoder per word
  for (genvar w = 0; w < NW; w++) begin : g_word
    localparam int ALM_OFS = OFS_ALM_LO + w * BYTES_PER_WORD;
    localparam int RLD_OFS = OFS_RLD_LO + w * BYTES_PER_WORD;

    always_ff @(posedge clk) begin
      if (rst) begin
        alarm_val[w*DW +: DW] <= '0;
      end else if (we && (addr == AW'(ALM_OFS))) begin
        alarm_val[w*DW +: DW] <= wdata;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        reload_val[w*DW +: DW] <= '0;
      end else if (we && (addr == AW'(RLD_OFS))) begin
        reload_val[w*DW +: DW] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_wr) begin
      cfg_q.run     <= wdata[CFG_RUN_BIT];
      cfg_q.up      <= wdata[CFG_UP_BIT];
      cfg_q.auto_rl <= wdata[CFG_ARL_BIT];
      cfg_q.armed   <= wdata[CFG_ARM_BIT];
    end else if (fire) begin
      cfg_q.armed   <= 1'b0;
    end
  end

  assign cfg = cfg_q;

  always_comb begin
    stat_d = stat_q;
    if (fire) begin
      stat_d = 1'b1;
    end else if (clr_wr && wdata[0]) begin
      stat_d = 1'b0;
    end
    mask_d = mask_wr ? wdata[0] : mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= 1'b0;
      mask_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      stat_q <= stat_d;
      mask_q <= mask_d;
      irq    <= stat_d & mask_d;
    end
  end

  always_comb begin
    cfg_word              = '0;
    cfg_word[CFG_RUN_BIT] = cfg_q.run;
    cfg_word[CFG_UP_BIT]  = cfg_q.up;
    cfg_word[CFG_ARL_BIT] = cfg_q.auto_rl;
    cfg_word[CFG_ARM_BIT] = cfg_q.armed;
  end

  always_comb begin
    rd_d = '0;
    case (addr)
      AW'(OFS_CFG):      rd_d = cfg_word;
      AW'(OFS_SNAP_LO):  rd_d = snap[0 +: DW];
      AW'(OFS_SNAP_HI):  rd_d = snap[DW +: DW];
      AW'(OFS_ALM_LO):   rd_d = alarm_val[0 +: DW];
      AW'(OFS_ALM_HI):   rd_d = alarm_val[DW +: DW];
      AW'(OFS_RLD_LO):   rd_d = reload_val[0 +: DW];
      AW'(OFS_RLD_HI):   rd_d = reload_val[DW +: DW];
      AW'(OFS_STAT_CLR): rd_d = DW'(stat_q);
      AW'(OFS_IRQ_MASK): rd_d = DW'(mask_q);
      default:           rd_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      rdata <= rd_d;
    end
  end
endmodule

// File: rtl/alarm_timer64.sv
module alarm_timer64
  import at_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam int CW = 2 * DW;

  tcfg_t          cfg;
  logic [CW-1:0]  cnt, snap, alarm_val, reload_val;
  logic           fire, load_req, snap_req, alarm_reload;

  assign alarm_reload = fire & cfg.auto_rl;

  at_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .addr       (bus_addr),
    .we         (bus_we),
    .wdata      (bus_wdata),
    .snap       (snap),
    .fire       (fire),
    .cfg        (cfg),
    .alarm_val  (alarm_val),
    .reload_val (reload_val),
    .load_req   (load_req),
    .snap_req   (snap_req),
    .rdata      (bus_rdata),
    .irq        (irq_o)
  );

  at_counter #(.W(CW)) u_cnt (
    .clk          (clk),
    .rst          (rst),
    .run          (cfg.run),
    .up           (cfg.up),
    .sw_load      (load_req),
    .alarm_reload (alarm_reload),
    .reload_val   (reload_val),
    .snap_req     (snap_req),
    .cnt_q        (cnt),
    .snap_q       (snap)
  );

  at_alarm #(.W(CW)) u_alarm (
    .cnt   (cnt),
    .alarm (alarm_val),
    .up    (cfg.up),
    .armed (cfg.armed),
    .fire  (fire)
  );
endmodule

// File: rtl/at_checker.sv
module at_checker #(
  parameter int W  = 64,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  cnt,
  input logic [W-1:0]  snap,
  input logic [W-1:0]  reload_val,
  input logic          run,
  input logic          up,
  input logic          auto_rl,
  input logic          armed,
  input logic          fire,
  input logic          load_req,
  input logic          snap_req
);
  logic cfg_wr;
  assign cfg_wr = bus_we && (bus_addr == AW'(at_pkg::OFS_CFG));

  a_r2_count_up: assert property (@(posedge clk) disable iff (rst)
    (run && up && !load_req && !fire) |=> (cnt == $past(cnt) + W'(1)));

  a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
    (run && !up && !load_req && !fire) |=> (cnt == $past(cnt) - W'(1)));

  a_r3_snap_holds: assert property (@(posedge clk) disable iff (rst)
    !snap_req |=> $stable(snap));

  a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (cnt == $past(reload_val)));

  a_r6_arm_clears: assert property (@(posedge clk) disable iff (rst)
    (fire && !cfg_wr) |=> !armed);

  a_r7_alarm_reload: assert property (@(posedge clk) disable iff (rst)
    (fire && auto_rl && !load_req) |=> (cnt == $past(reload_val)));
endmodule

bind alarm_timer64 at_checker #(.W(2*DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_we     (bus_we),
  .bus_addr   (bus_addr),
  .cnt        (cnt),
  .snap       (snap),
  .reload_val (reload_val),
  .run        (cfg.run),
  .up         (cfg.up),
  .auto_rl    (cfg.auto_rl),
  .armed      (cfg.armed),
  .fire       (fire),
  .load_req   (load_req),
  .snap_req   (snap_req)
);

// File: tb/test_alarm_timer64.sv
`timescale 1ns/1ps
module test_alarm_timer64;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  a   = '0;
  logic        we  = 1'b0;
  logic [31:0] wd  = '0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alarm_timer64 i_alarm_timer64 (
    .clk(clk), .rst(rst), .bus_addr(a), .bus_we(we),
    .bus_wdata(wd), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // ---------------- behavioural reference ----------------
  longint unsigned m_cnt, m_alm, m_rld, m_snap;
  bit m_run, m_up, m_arl, m_arm, m_st, m_ie;
  logic [31:0] exp_rd;
  bit exp_irq;

  function automatic logic [31:0] m_read(input logic [5:0] ad);
    case (ad)
      6'h00: return {m_run, m_up, m_arl, 18'd0, m_arm, 10'd0};
      6'h04: return m_snap[31:0];
      6'h08: return m_snap[63:32];
      6'h10: return m_alm[31:0];
      6'h14: return m_alm[63:32];
      6'h18: return m_rld[31:0];
      6'h1C: return m_rld[63:32];
      6'h24: return {31'd0, m_st};
      6'h28: return {31'd0, m_ie};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_alm = 0; m_rld = 0; m_snap = 0;
      m_run = 0; m_up = 1; m_arl = 0; m_arm = 0; m_st = 0; m_ie = 0;
      exp_rd = 0; exp_irq = 0;
    end else begin
      bit hit;
      longint unsigned old_cnt, old_rld;
      exp_rd  = m_read(a);
      hit     = m_arm && (m_up ? (m_cnt >= m_alm) : (m_cnt <= m_alm));
      old_cnt = m_cnt;
      old_rld = m_rld;
      if (we && a == 6'h20)      m_cnt = old_rld;
      else if (hit && m_arl)     m_cnt = old_rld;
      else if (m_run)            m_cnt = m_up ? old_cnt + 1 : old_cnt - 1;
      if (we && a == 6'h0C) m_snap = old_cnt;
      if (we && a == 6'h00) begin
        m_run = wd[31]; m_up = wd[30]; m_arl = wd[29]; m_arm = wd[10];
      end else if (hit) m_arm = 0;
      if (we && a == 6'h10) m_alm[31:0]  = wd;
      if (we && a == 6'h14) m_alm[63:32] = wd;
      if (we && a == 6'h18) m_rld[31:0]  = wd;
      if (we && a == 6'h1C) m_rld[63:32] = wd;
      if (hit) m_st = 1;
      else if (we && a == 6'h24 && wd[0]) m_st = 0;
      if (we && a == 6'h28) m_ie = wd[0];
      exp_irq = m_st & m_ie;
    end
  end

  // Every-clock comparison (all requirements, timing of R9)
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_cmp++;
      if (bus_rdata !== exp_rd || irq_o !== exp_irq) begin
        n_bad++;
        $display("FAIL R9 per-cycle model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 bus_rdata, irq_o, exp_rd, exp_irq);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [5:0] ad, input logic [31:0] d);
    a = ad; wd = d; we = 1'b1;
    @(posedge clk); @(negedge clk);
    we = 1'b0; wd = '0;
  endtask

  task automatic rd(input logic [5:0] ad, output logic [31:0] d);
    a = ad; we = 1'b0;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    report();
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    // R1 reset state
    rd(6'h00, v); chk("R1 cfg reset", v, 32'h4000_0000);
    rd(6'h10, v); chk("R1 alarm lo reset", v, 32'h0);
    chk("R1 irq reset", {31'd0, irq_o}, 32'h0);

    // R9 readback, unmapped and read-only offsets
    wr(6'h10, 32'h1234_5678);
    rd(6'h10, v); chk("R9 alarm lo readback", v, 32'h1234_5678);
    rd(6'h3C, v); chk("R9 unmapped reads zero", v, 32'h0);
    wr(6'h04, 32'hDEAD_BEEF);
    wr(6'h0C, 32'h0);
    rd(6'h04, v); chk("R9 write to count low ignored", v, 32'h0);

    // R4 load from reload value
    wr(6'h18, 32'hFFFF_FFFC);
    wr(6'h1C, 32'h0000_0005);
    wr(6'h20, 32'h0);
    wr(6'h0C, 32'h0);
    rd(6'h04, v); chk("R4 load low", v, 32'hFFFF_FFFC);
    rd(6'h08, v); chk("R4 load high", v, 32'h0000_0005);

    // R2 / R3 count across a 32-bit carry, snapshot coherence and hold
    wr(6'h00, 32'hC000_0000);
    idle(5);
    wr(6'h0C, 32'h0);
    rd(6'h04, v); chk("R3 snapshot low after carry", v, 32'h0000_0001);
    rd(6'h08, v); chk("R3 snapshot high after carry", v, 32'h0000_0006);
    idle(20);
    rd(6'h04, v); chk("R3 snapshot low holds", v, 32'h0000_0001);

    // R10 direction change, R2 down counting
    wr(6'h00, 32'h4000_0000);
    wr(6'h18, 32'd100);
    wr(6'h1C, 32'd0);
    wr(6'h20, 32'h0);
    wr(6'h00, 32'h8000_0000);
    idle(10);
    wr(6'h0C, 32'h0);
    rd(6'h04, v); chk("R10 down count after direction change", v, 32'd90);

    // R5 late alarm counting down, R6 self clear, R8 interrupt
    wr(6'h14, 32'd0);
    wr(6'h10, 32'd1000);
    wr(6'h28, 32'h1);
    wr(6'h00, 32'h8000_0400);
    idle(1);
    rd(6'h24, v); chk("R5 late alarm down fires", v, 32'h1);
    chk("R8 irq with mask set", {31'd0, irq_o}, 32'h1);
    rd(6'h00, v); chk("R6 arm bit cleared", v, 32'h8000_0000);

    // R8 clear semantics
    wr(6'h24, 32'h0);
    rd(6'h24, v); chk("R8 write 0 keeps status", v, 32'h1);
    wr(6'h24, 32'h1);
    rd(6'h24, v); chk("R8 write 1 clears status", v, 32'h0);
    chk("R8 irq low after clear", {31'd0, irq_o}, 32'h0);

    // R5 late alarm counting up
    wr(6'h00, 32'h4000_0000);
    wr(6'h10, 32'd5);
    wr(6'h00, 32'hC000_0400);
    idle(1);
    rd(6'h24, v); chk("R5 late alarm up fires", v, 32'h1);
    wr(6'h24, 32'h1);

    // R5 exact equality while counting up
    wr(6'h00, 32'h4000_0000);
    wr(6'h18, 32'd0);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'd20);
    wr(6'h00, 32'hC000_0400);
    idle(5);
    rd(6'h24, v); chk("R5 no alarm before equality", v, 32'h0);
    idle(30);
    rd(6'h24, v); chk("R5 alarm on equality", v, 32'h1);
    wr(6'h24, 32'h1);

    // R7 auto-reload counting down
    wr(6'h00, 32'h4000_0000);
    wr(6'h18, 32'd50);
    wr(6'h20, 32'h0);
    wr(6'h10, 32'd40);
    wr(6'h00, 32'hA000_0400);
    idle(12);
    wr(6'h0C, 32'h0);
    rd(6'h04, v); chk("R7 count reloaded on alarm", v, 32'd49);
    rd(6'h24, v); chk("R7 alarm status set", v, 32'h1);

    idle(4);
    report();
  end
endmodule